// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter. It waits in the acquisition phase with the sampling switches closed and its analog section powered down. A falling edge on the active-low chip-select input starts a conversion. The sampling switches open first. The capacitor arrays then go to ground for a fixed hold interval. After that the block runs a binary search over the code, MSB first. Each step drives a trial code to an external capacitive DAC, waits for it to settle, then keeps or clears the trial bit according to a one-bit comparator result.

After the LSB is resolved, the block goes back to acquisition and powers down. It presents the code with a one-cycle done pulse. The code belongs to the sample just taken, with no pipeline delay. A busy flag covers the whole conversion. Any further chip-select edge during that time has no effect.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted and after its release, the block is in acquisition: sw_sample_o=1, sw_hold_o=0, sw_cmp_o=0, busy_o=0, done_o=0, pdown_o=1, dac_code_o=0, code_o=0.
- R2: A conversion starts at a clock edge where cs_ni is sampled low after being sampled high on the previous edge. From the next cycle, busy_o=1, pdown_o=0, sw_hold_o=1, sw_sample_o=0 and dac_code_o=0 for HOLD_CYC cycles.
- R3: The compare phase (sw_cmp_o=1) tries bits from MSB to LSB. The first trial code has only bit WIDTH-1 set. Each trial code is the bits already resolved OR the current bit, and each is held for SETTLE_CYC cycles.
- R4: cmp_i=1 means the input is at or above the DAC level. cmp_i is sampled in the last cycle of a step. The current bit is kept when cmp_i=1 and cleared when cmp_i=0.
- R5: Counting the first busy cycle as cycle 1, done_o is high for exactly one cycle, in cycle HOLD_CYC+WIDTH*SETTLE_CYC+1. In that same cycle code_o shows the result and busy_o has returned to 0.
- R6: pdown_o is 1 whenever no conversion is in progress, including the cycle of the done pulse, and 0 while busy_o=1.
- R7: Each result belongs to the sample of its own conversion. Back-to-back conversions of different inputs each return their own code.
- R8: An input above full scale (comparator always 1) gives all ones. An input below zero (comparator always 0) gives all zeros.
- R9: A falling edge of cs_ni while busy_o=1 is ignored. The running conversion neither restarts nor stretches.
- R10: Holding cs_ni low after a conversion does not start another one. A new conversion needs cs_ni to go high and then low again.
- R11: Exactly one of sw_sample_o, sw_hold_o and sw_cmp_o is 1 in every cycle.
- R12: code_o changes only in the cycle done_o is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; falling edge triggers a conversion |
| cmp_i | input | 1 | Comparator result, 1 when input is at or above the DAC level |
| dac_code_o | output | WIDTH | Trial code to the capacitive DAC; zero outside the compare phase |
| sw_sample_o | output | 1 | Sampling switches closed (acquisition phase) |
| sw_hold_o | output | 1 | Arrays switched to ground, inputs open (hold phase) |
| sw_cmp_o | output | 1 | Bit trials in progress (compare phase) |
| busy_o | output | 1 | Conversion in progress |
| pdown_o | output | 1 | Analog section powered down |
| done_o | output | 1 | One-cycle pulse when a new code is available |
| code_o | output | WIDTH | Last conversion result, unsigned straight binary |

## Verification
The bench builds the block with WIDTH=16, HOLD_CYC=2 and SETTLE_CYC=2. These values exercise both the hold counter and the settle counter beyond their single-cycle case, so the hold length, the step length and the done cycle all move with the parameters and are checked at their computed positions. With the full 16-bit width, the bench can drive inputs at midscale, at either side of it, at both ends of the range and outside the range. An ideal threshold comparator around the DAC code lets every expected result be the input value itself, clamped to the range.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_ACQ  = 2'd0,
    PH_HOLD = 2'd1,
    PH_CMP  = 2'd2
  } phase_e;

  localparam int unsigned NUM_PHASES = 3;

endpackage

// File: rtl/sar_seq_trig.sv
module sar_seq_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic fall_o
);

  logic cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_ni;
  end

  assign fall_o = cs_q & ~cs_ni;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned SETTLE_CYC = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fall_i,
  input  logic   last_bit_i,
  output phase_e phase_o,
  output logic   load_o,
  output logic   step_o,
  output logic   finish_o
);

  localparam int unsigned HCW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam int unsigned SCW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [HCW-1:0] H_LAST = HCW'(HOLD_CYC - 1);
  localparam logic [SCW-1:0] S_LAST = SCW'(SETTLE_CYC - 1);

  phase_e         phase_q;
  logic [HCW-1:0] hcnt_q;
  logic [SCW-1:0] scnt_q;

  assign load_o   = (phase_q == PH_ACQ) && fall_i;
  assign step_o   = (phase_q == PH_CMP) && (scnt_q == S_LAST);
  assign finish_o = step_o && last_bit_i;
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACQ;
      hcnt_q  <= '0;
      scnt_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_ACQ: begin
          if (fall_i) begin
            phase_q <= PH_HOLD;
            hcnt_q  <= '0;
          end
        end
        PH_HOLD: begin
          if (hcnt_q == H_LAST) begin
            phase_q <= PH_CMP;
            scnt_q  <= '0;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        PH_CMP: begin
          if (scnt_q == S_LAST) begin
            scnt_q <= '0;
            if (last_bit_i) phase_q <= PH_ACQ;
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_ACQ;
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_search.sv
module sar_seq_search #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             last_o
);

  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mask_q;

  assign trial_o  = acc_q | mask_q;
  // decision folded in so the final code is ready at the last step
  assign result_o = cmp_i ? trial_o : acc_q;
  assign last_o   = mask_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mask_q <= TOP_BIT;
    end else if (load_i) begin
      acc_q  <= '0;
      mask_q <= TOP_BIT;
    end else if (step_i) begin
      acc_q  <= result_o;
      mask_q <= mask_q >> 1;
    end
  end

endmodule

// File: rtl/sar_seq_out.sv
module sar_seq_out
  import sar_seq_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic             finish_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic [WIDTH-1:0] trial_i,
  output logic [NUM_PHASES-1:0] sw_o,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_o,
  output logic             pdown_o,
  output logic             done_o,
  output logic [WIDTH-1:0] code_o
);

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_sw
    assign sw_o[g] = (phase_i == phase_e'(g));
  end

  assign dac_code_o = (phase_i == PH_CMP) ? trial_i : '0;
  assign busy_o     = (phase_i != PH_ACQ);
  assign pdown_o    = (phase_i == PH_ACQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      code_o <= '0;
    end else begin
      done_o <= finish_i;
      if (finish_i) code_o <= result_i;
    end
  end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned WIDTH      = 16,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned SETTLE_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             sw_sample_o,
  output logic             sw_hold_o,
  output logic             sw_cmp_o,
  output logic             busy_o,
  output logic             pdown_o,
  output logic             done_o,
  output logic [WIDTH-1:0] code_o
);

  logic                  fall;
  logic                  load;
  logic                  step;
  logic                  finish;
  logic                  last_bit;
  phase_e                phase;
  logic [WIDTH-1:0]      trial;
  logic [WIDTH-1:0]      result;
  logic [NUM_PHASES-1:0] sw;

  sar_seq_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .fall_o (fall)
  );

  sar_seq_ctrl #(
    .HOLD_CYC   (HOLD_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .last_bit_i (last_bit),
    .phase_o    (phase),
    .load_o     (load),
    .step_o     (step),
    .finish_o   (finish)
  );

  sar_seq_search #(
    .WIDTH (WIDTH)
  ) u_search (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .cmp_i    (cmp_i),
    .trial_o  (trial),
    .result_o (result),
    .last_o   (last_bit)
  );

  sar_seq_out #(
    .WIDTH (WIDTH)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .finish_i   (finish),
    .result_i   (result),
    .trial_i    (trial),
    .sw_o       (sw),
    .dac_code_o (dac_code_o),
    .busy_o     (busy_o),
    .pdown_o    (pdown_o),
    .done_o     (done_o),
    .code_o     (code_o)
  );

  assign sw_sample_o = sw[PH_ACQ];
  assign sw_hold_o   = sw[PH_HOLD];
  assign sw_cmp_o    = sw[PH_CMP];

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             sw_sample_o,
  input logic             sw_hold_o,
  input logic             sw_cmp_o,
  input logic             busy_o,
  input logic             pdown_o,
  input logic             done_o,
  input logic [WIDTH-1:0] code_o
);

  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  p_sw_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sw_sample_o, sw_hold_o, sw_cmp_o}) == 1);

  p_start_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sw_hold_o && !pdown_o && (dac_code_o == '0) && !$past(cs_ni));

  p_hold_from_acq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_hold_o) |-> $past(sw_sample_o));

  p_cmp_after_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_cmp_o) |-> $past(sw_hold_o));

  p_first_trial_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_cmp_o) |-> dac_code_o == TOP_BIT);

  p_trial_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_cmp_o |-> dac_code_o != '0);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(sw_cmp_o));

  p_pdown_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pdown_o && sw_sample_o);

  p_code_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(code_o));

  p_acq_dac_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_sample_o |-> dac_code_o == '0);

endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .dac_code_o  (dac_code_o),
  .sw_sample_o (sw_sample_o),
  .sw_hold_o   (sw_hold_o),
  .sw_cmp_o    (sw_cmp_o),
  .busy_o      (busy_o),
  .pdown_o     (pdown_o),
  .done_o      (done_o),
  .code_o      (code_o)
);

// File: tb/sar_seq_test.sv
`timescale 1ns/1ps
module sar_seq_test;

  localparam int W      = 16;
  localparam int HOLD   = 2;
  localparam int SETTLE = 2;
  localparam int TOTAL  = HOLD + W * SETTLE;
  localparam int MAXC   = (1 << W) - 1;
  localparam int TOPB   = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cs_ni = 1'b1;
  logic         cmp;
  logic [W-1:0] dac_code;
  logic         sw_sample, sw_hold, sw_cmp;
  logic         busy, pdown, done;
  logic [W-1:0] code;
  int           vin = 0;
  int           checks = 0;
  int           errors = 0;

  always #10 clk = ~clk;

  // ideal comparator: input at or above DAC level
  always_comb cmp = (vin >= int'(dac_code));

  sar_seq #(.WIDTH(W), .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .cmp_i       (cmp),
    .dac_code_o  (dac_code),
    .sw_sample_o (sw_sample),
    .sw_hold_o   (sw_hold),
    .sw_cmp_o    (sw_cmp),
    .busy_o      (busy),
    .pdown_o     (pdown),
    .done_o      (done),
    .code_o      (code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    cs_ni  = 1'b1;
    repeat (3) @(negedge clk);
    chk(sw_sample && !sw_hold && !sw_cmp, "R1", "switches in reset",
        {sw_sample, sw_hold, sw_cmp}, 3'b100);
    chk(!busy && !done && pdown, "R1", "busy/done/pdown in reset",
        {busy, done, pdown}, 3'b001);
    chk(dac_code == '0 && code == '0, "R1", "codes in reset", code, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(sw_sample && !busy && pdown && !done, "R1", "idle after reset",
        {sw_sample, busy, pdown, done}, 4'b1010);
  endtask

  task automatic t_conv(input int v, input bit glitch, input string req);
    int exp_code = (v < 0) ? 0 : (v > MAXC) ? MAXC : v;
    int exp_second = (exp_code & TOPB) | (TOPB >> 1);
    vin = v;
    @(negedge clk); cs_ni = 1'b1;
    @(negedge clk); cs_ni = 1'b0;
    for (int k = 1; k <= TOTAL + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(busy && !pdown && sw_hold && !sw_sample, "R2", "start phase",
            {busy, pdown, sw_hold, sw_sample}, 4'b1010);
        chk(dac_code == '0, "R2", "dac grounded in hold", dac_code, 0);
      end
      if (k == HOLD) chk(sw_hold && dac_code == '0, "R2", "hold length",
                         {sw_hold, sw_cmp}, 2'b10);
      if (k == HOLD + 1) chk(sw_cmp && int'(dac_code) == TOPB, "R3",
                             "first trial", dac_code, TOPB);
      if (k == HOLD + SETTLE) chk(int'(dac_code) == TOPB, "R3",
                                  "first trial held", dac_code, TOPB);
      if (k == HOLD + SETTLE + 1) chk(int'(dac_code) == exp_second, "R4",
                                      "second trial", dac_code, exp_second);
      if (k == TOTAL) chk(busy && !done && !pdown, "R5", "still busy before done",
                          {busy, done, pdown}, 3'b100);
      if (k == TOTAL + 1) begin
        chk(done && !busy, "R5", "done pulse timing", {done, busy}, 2'b10);
        chk(pdown && sw_sample, "R6", "powered down at done",
            {pdown, sw_sample}, 2'b11);
        chk(int'(code) == exp_code, req, "result code", code, exp_code);
      end
      if (glitch && k == 5) cs_ni = 1'b1;
      if (glitch && k == 7) cs_ni = 1'b0;
      if (glitch && k == 9) chk(busy && sw_cmp, "R9", "edge while busy ignored",
                                {busy, sw_cmp}, 2'b11);
    end
    @(negedge clk);
    chk(!done && int'(code) == exp_code, "R12", "code held after done",
        code, exp_code);
  endtask

  task automatic t_hold_low();
    bit started = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy || !pdown) started = 1'b1;
    end
    chk(!started && cs_ni == 1'b0, "R10", "no restart with cs held low",
        started, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_conv(32768, 1'b0, "R4");
    t_conv(32767, 1'b0, "R4");
    t_conv(16'h1234, 1'b0, "R7");
    t_conv(16'hEDCB, 1'b0, "R7");
    t_conv(16'hA5C3, 1'b0, "R3");
    t_conv(0, 1'b0, "R4");
    t_conv(MAXC, 1'b0, "R4");
    t_conv(70000, 1'b0, "R8");
    t_conv(-5, 1'b0, "R8");
    t_conv(16'h5A3C, 1'b1, "R9");
    t_hold_low();
    t_conv(16'h0F0F, 1'b0, "R10");
    chk(sw_sample && !sw_hold && !sw_cmp, "R11", "single switch phase idle",
        {sw_sample, sw_hold, sw_cmp}, 3'b100);
    finish_run();
  end

endmodule